// File: doc/BRIEF.md
# Configuration Access Lock Controller

This block sits between a programming port and a configuration memory and decides, on every cycle, whether an erase, a program or a readback request may pass. A small lock machine has three positions: open, locked under a 128-bit key, and sealed for good. A key lock can be undone by presenting the same key. The sealed position is final. A separate one-time-programmable flag forbids erase and program for ever, whatever the lock position, while readback stays governed by the lock alone.

Commands arrive as a two-bit opcode with a valid strobe and a 128-bit key word. Two active-low synchronous resets are provided. `por_n` models loss of power to the non-volatile store and clears everything. `rst_n` is the ordinary soft reset. The lock position, the stored key and the one-time flag all survive it. The grant outputs are combinational, so a request is answered in the same cycle it is raised.

Top module: `cal_lock_ctrl`

## Requirements
- R1: After `por_n` is held low for a clock edge, `lock_state` is 0 (open), `otp_mode` is 0 and `key_err` is 0, so every request is granted.
- R2: Opcode 0 (key lock) with `cmd_valid` moves an open block to `lock_state` 1 and stores `cmd_key`. In any other position it is ignored and the stored key is kept.
- R3: Opcode 1 (unlock) in position 1 returns the block to 0 only if all 128 bits of `cmd_key` equal the stored key. In positions 0 and 2 it is ignored and raises no error.
- R4: An unlock in position 1 with any key bit wrong leaves the position unchanged. `key_err` is 1 for exactly the cycle after that command edge.
- R5: Opcode 2 (seal) moves position 0 or 1 to `lock_state` 2. No command or soft reset ever leaves position 2.
- R6: Opcode 3 sets `otp_mode` from any position without changing `lock_state`. Only `por_n` clears it.
- R7: `gnt_read` equals `req_read` while `lock_state` is 0 and is 0 otherwise.
- R8: `gnt_erase` and `gnt_prog` equal their requests only while `lock_state` is 0 and `otp_mode` is 0. Otherwise they are 0.
- R9: While `rst_n` is low, commands are ignored and `key_err` is cleared. `lock_state`, the stored key and `otp_mode` are kept.
- R10: A grant follows its request within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-loss reset, active low, synchronous; clears persistent state |
| rst_n | input | 1 | Soft reset, active low, synchronous; persistent state kept |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 key lock, 1 unlock, 2 seal, 3 set one-time mode |
| cmd_key | input | 128 | Key supplied with key lock and unlock |
| req_erase | input | 1 | Erase request |
| req_prog | input | 1 | Program request |
| req_read | input | 1 | Readback request |
| gnt_erase | output | 1 | Erase permitted |
| gnt_prog | output | 1 | Program permitted |
| gnt_read | output | 1 | Readback permitted |
| lock_state | output | 2 | 0 open, 1 key-locked, 2 sealed |
| otp_mode | output | 1 | One-time-programmable flag |
| key_err | output | 1 | One-cycle pulse after a rejected unlock |

## Verification
The hardest case to reach from the ports is a near-miss key. These are keys that differ from the stored one in a single bit at either end of the word, and they show whether every lane of the comparator takes part. The vector table locks with one key, tries to replace it, and then offers the other key, the key with its lowest bit flipped and the key with its top bit flipped. Only after that does it offer the true key. A second hard case is the combination of states that survives a soft reset: one-time mode set while key-locked, followed by a seal from the key-locked position. Directed steps after the table build this up, issuing commands while `rst_n` is low.

// File: rtl/cal_pkg.sv
// Package cal_pkg
// Shared encodings for the configuration access lock controller.
// Assumes a two-bit opcode and a two-bit lock position code.
package cal_pkg;

    localparam int unsigned CAL_OP_W = 2;
    localparam int unsigned CAL_ST_W = 2;

    typedef enum logic [CAL_ST_W-1:0] {
        LK_OPEN   = 2'd0,
        LK_KEYED  = 2'd1,
        LK_SEALED = 2'd2,
        LK_SPARE  = 2'd3
    } lk_state_e;

    typedef enum logic [CAL_OP_W-1:0] {
        OP_KEYLOCK = 2'd0,
        OP_UNLOCK  = 2'd1,
        OP_SEAL    = 2'd2,
        OP_OTP     = 2'd3
    } lk_op_e;

endpackage

// File: rtl/cal_key_cmp.sv
// Module cal_key_cmp
// Compares a presented key with the stored key. The key is split into
// LANES equal slices that are compared in parallel and then AND-reduced.
// Assumes KEY_W is a multiple of LANES. Purely combinational.
module cal_key_cmp #(
    parameter int unsigned KEY_W = 128,
    parameter int unsigned LANES = 4
) (
    input  logic [KEY_W-1:0] key_a,
    input  logic [KEY_W-1:0] key_b,
    output logic             same
);
    localparam int unsigned LANE_W = KEY_W / LANES;

    logic [LANES-1:0] lane_eq;

    // Per-lane equality of one key slice.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (key_a[g*LANE_W +: LANE_W] == key_b[g*LANE_W +: LANE_W]);
    end

    // All lanes must agree for a match.
    assign same = &lane_eq;

    initial begin
        assert (LANE_W * LANES == KEY_W)
            else $error("key width not divisible by lane count");
    end
endmodule

// File: rtl/cal_lock_fsm.sv
// Module cal_lock_fsm
// Holds the lock position, the stored key and the one-time flag. These
// registers stand in for non-volatile storage: only por_n clears them.
// The soft reset rst_n suppresses commands and clears the error pulse.
// Assumes the key match input is computed from key_q and cmd_key.
module cal_lock_fsm
    import cal_pkg::*;
#(
    parameter int unsigned KEY_W = 128
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [CAL_OP_W-1:0] cmd_op,
    input  logic [KEY_W-1:0]    cmd_key,
    input  logic                key_match,
    output lk_state_e           st_q,
    output logic                otp_q,
    output logic                key_err_q,
    output logic [KEY_W-1:0]    key_q
);
    lk_state_e          st_d;
    logic               otp_d;
    logic               kerr_d;
    logic [KEY_W-1:0]   key_d;
    logic               cmd_act;

    // Commands are only acted on outside soft reset.
    assign cmd_act = cmd_valid && rst_n;

    // Next-state decode for lock position, key store and error pulse.
    always_comb begin
        st_d   = st_q;
        key_d  = key_q;
        otp_d  = otp_q;
        kerr_d = 1'b0;
        if (cmd_act) begin
            unique case (cmd_op)
                OP_KEYLOCK: begin
                    if (st_q == LK_OPEN) begin
                        st_d  = LK_KEYED;
                        key_d = cmd_key;
                    end
                end
                OP_UNLOCK: begin
                    if (st_q == LK_KEYED) begin
                        if (key_match) st_d   = LK_OPEN;
                        else           kerr_d = 1'b1;
                    end
                end
                OP_SEAL: begin
                    if (st_q == LK_OPEN || st_q == LK_KEYED) st_d = LK_SEALED;
                end
                OP_OTP: otp_d = 1'b1;
                default: ;
            endcase
        end
        // The unused code is treated as sealed and never left.
        if (st_q == LK_SPARE) st_d = LK_SPARE;
    end

    // Persistent registers: cleared only by power-loss reset.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            st_q  <= LK_OPEN;
            otp_q <= 1'b0;
            key_q <= '0;
        end else begin
            st_q  <= st_d;
            otp_q <= otp_d;
            key_q <= key_d;
        end
    end

    // Volatile error pulse: cleared by either reset.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) key_err_q <= 1'b0;
        else                  key_err_q <= kerr_d;
    end

    AST_SEALED_STAYS: assert property (@(posedge clk) disable iff (!por_n)
        (st_q == LK_SEALED) |=> (st_q == LK_SEALED)); // R5
    AST_OTP_STAYS: assert property (@(posedge clk) disable iff (!por_n)
        otp_q |=> otp_q); // R6
    AST_NO_KEYLESS_OPEN: assert property (@(posedge clk) disable iff (!por_n)
        (st_q == LK_KEYED && !(cmd_valid && rst_n && cmd_op == OP_UNLOCK && key_match))
        |=> (st_q != LK_OPEN)); // R3
    AST_KEYERR_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
        key_err_q |-> $past(cmd_valid && rst_n && cmd_op == OP_UNLOCK
                            && st_q == LK_KEYED && !key_match)); // R4
    AST_SOFT_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> ($stable(st_q) && $stable(otp_q) && !key_err_q)); // R9
endmodule

// File: rtl/cal_grant.sv
// Module cal_grant
// Combinational gating of access requests. Readback needs the open
// position; write-type requests (erase, program) also need the
// one-time flag clear. Assumes inputs come from registered state.
module cal_grant #(
    parameter int unsigned N_WR = 2
) (
    input  logic            is_open,
    input  logic            otp,
    input  logic            rd_req,
    input  logic [N_WR-1:0] wr_req,
    output logic            rd_gnt,
    output logic [N_WR-1:0] wr_gnt
);
    // Readback gate.
    assign rd_gnt = rd_req && is_open;

    // One gate per write-type channel.
    for (genvar g = 0; g < N_WR; g++) begin : g_wr
        assign wr_gnt[g] = wr_req[g] && is_open && !otp;
    end
endmodule

// File: rtl/cal_lock_ctrl.sv
// Module cal_lock_ctrl
// Top of the configuration access lock controller: ties the key
// comparator, the lock machine and the grant gates together.
// Assumes requests are held by the requester while it uses a grant.
module cal_lock_ctrl
    import cal_pkg::*;
#(
    parameter int unsigned KEY_W     = 128,
    parameter int unsigned CMP_LANES = 4
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [CAL_OP_W-1:0] cmd_op,
    input  logic [KEY_W-1:0]    cmd_key,
    input  logic                req_erase,
    input  logic                req_prog,
    input  logic                req_read,
    output logic                gnt_erase,
    output logic                gnt_prog,
    output logic                gnt_read,
    output logic [CAL_ST_W-1:0] lock_state,
    output logic                otp_mode,
    output logic                key_err
);
    localparam int unsigned N_WR = 2;

    lk_state_e          st;
    logic               match;
    logic [KEY_W-1:0]   stored_key;
    logic [N_WR-1:0]    wr_req;
    logic [N_WR-1:0]    wr_gnt;

    // Key comparison against the stored key.
    cal_key_cmp #(.KEY_W(KEY_W), .LANES(CMP_LANES)) u_cmp (
        .key_a (cmd_key),
        .key_b (stored_key),
        .same  (match)
    );

    // Lock position, key store and one-time flag.
    cal_lock_fsm #(.KEY_W(KEY_W)) u_fsm (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_key   (cmd_key),
        .key_match (match),
        .st_q      (st),
        .otp_q     (otp_mode),
        .key_err_q (key_err),
        .key_q     (stored_key)
    );

    // Pack write-type requests: bit 1 erase, bit 0 program.
    assign wr_req = {req_erase, req_prog};

    // Access gating.
    cal_grant #(.N_WR(N_WR)) u_gnt (
        .is_open (st == LK_OPEN),
        .otp     (otp_mode),
        .rd_req  (req_read),
        .wr_req  (wr_req),
        .rd_gnt  (gnt_read),
        .wr_gnt  (wr_gnt)
    );

    assign gnt_erase  = wr_gnt[1];
    assign gnt_prog   = wr_gnt[0];
    assign lock_state = st;

    AST_READ_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!por_n)
        gnt_read |-> (lock_state == LK_OPEN)); // R7
    AST_WRITE_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
        (gnt_erase || gnt_prog) |-> (!otp_mode && lock_state == LK_OPEN)); // R8
endmodule

// File: tb/sim_cal_lock_ctrl.sv
`timescale 1ns/1ps
module sim_cal_lock_ctrl;
    localparam int KW = 128;
    localparam int NV = 16;
    localparam logic [KW-1:0] KA = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211;
    localparam logic [KW-1:0] KB = 128'hA5A5_0F0F_1234_5678_9ABC_DEF0_5555_AAAA;

    logic clk = 1'b0;
    logic por_n = 1'b0, rst_n = 1'b1;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [KW-1:0] cmd_key = '0;
    logic req_erase = 1'b0, req_prog = 1'b0, req_read = 1'b0;
    logic gnt_erase, gnt_prog, gnt_read, otp_mode, key_err;
    logic [1:0] lock_state;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cal_lock_ctrl u0 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_key(cmd_key), .req_erase(req_erase),
        .req_prog(req_prog), .req_read(req_read), .gnt_erase(gnt_erase),
        .gnt_prog(gnt_prog), .gnt_read(gnt_read), .lock_state(lock_state),
        .otp_mode(otp_mode), .key_err(key_err)
    );

    // Vector: [14]valid [13:12]op [11:10]key sel [9:7]req{e,p,r}
    //         [6:5]state [4]otp [3]key_err [2:0]gnt{e,p,r}
    localparam logic [14:0] VEC [NV] = '{
        15'b0_00_00_111_00_0_0_111, // R7 open grants all
        15'b1_01_00_111_00_0_0_111, // R3 unlock when open ignored
        15'b1_00_00_111_01_0_0_000, // R2 key lock with KA
        15'b1_00_01_111_01_0_0_000, // R2 key lock again ignored
        15'b1_01_01_111_01_0_1_000, // R4 wrong key KB
        15'b1_01_10_111_01_0_1_000, // R4 lowest bit flipped
        15'b1_01_11_111_01_0_1_000, // R4 top bit flipped
        15'b0_00_00_111_01_0_0_000, // R4 pulse ends
        15'b1_01_00_111_00_0_0_111, // R3 correct key opens
        15'b1_11_00_111_00_1_0_001, // R8 otp blocks writes
        15'b1_00_01_111_01_1_0_000, // R6 lock under otp
        15'b1_01_01_111_00_1_0_001, // R6 unlock under otp
        15'b1_10_00_111_10_1_0_000, // R5 seal
        15'b1_01_01_111_10_1_0_000, // R5 unlock after seal
        15'b1_00_00_111_10_1_0_000, // R5 key lock after seal
        15'b0_00_00_001_10_1_0_000  // R7 sealed read denied
    };
    string vtag [NV] = '{"R7","R3","R2","R2","R4","R4","R4","R4",
                         "R3","R8","R6","R6","R5","R5","R5","R7"};

    function automatic logic [KW-1:0] key_of(input logic [1:0] s);
        case (s)
            2'd0: return KA;
            2'd1: return KB;
            2'd2: return KA ^ 128'd1;
            default: return KA ^ (128'd1 << 127);
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Apply one command and request set at a falling edge, clear the
    // strobe just after the rising edge; requests stay applied.
    task automatic step(input logic v, input logic [1:0] op,
                        input logic [KW-1:0] k, input logic [2:0] rq);
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_key = k;
        {req_erase, req_prog, req_read} = rq;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    task automatic check_all(input string tag, input logic [1:0] st,
                             input logic otp, input logic ke, input logic [2:0] g);
        chk({tag, " state"}, 32'(lock_state), 32'(st));
        chk({tag, " otp"}, 32'(otp_mode), 32'(otp));
        chk({tag, " key_err"}, 32'(key_err), 32'(ke));
        chk({tag, " grants"}, 32'({gnt_erase, gnt_prog, gnt_read}), 32'(g));
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        por_n = 1'b1;
        {req_erase, req_prog, req_read} = 3'b111;
        #1 check_all("R1 power-on", 2'd0, 1'b0, 1'b0, 3'b111);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][14], VEC[i][13:12], key_of(VEC[i][11:10]), VEC[i][9:7]);
            check_all($sformatf("%s vec%0d", vtag[i], i),
                      VEC[i][6:5], VEC[i][4], VEC[i][3], VEC[i][2:0]);
        end

        // R9: soft reset keeps sealed position and otp flag
        @(negedge clk); rst_n = 1'b0;
        step(1'b1, 2'd1, KB, 3'b111);
        check_all("R9 soft reset sealed", 2'd2, 1'b1, 1'b0, 3'b000);
        @(negedge clk); rst_n = 1'b1;

        // R1: power-loss reset clears everything
        @(negedge clk); por_n = 1'b0;
        @(posedge clk); #1;
        @(negedge clk); por_n = 1'b1;
        #1 check_all("R1 after por", 2'd0, 1'b0, 1'b0, 3'b111);

        // R10: grants track requests with no clock edge
        @(negedge clk);
        {req_erase, req_prog, req_read} = 3'b010;
        #0.5 chk("R10 same-cycle grant", 32'({gnt_erase, gnt_prog, gnt_read}), 32'b010);
        {req_erase, req_prog, req_read} = 3'b101;
        #0.5 chk("R10 same-cycle grant 2", 32'({gnt_erase, gnt_prog, gnt_read}), 32'b101);

        // R9: command during soft reset ignored
        @(negedge clk); rst_n = 1'b0;
        step(1'b1, 2'd0, KA, 3'b111);
        check_all("R9 lock ignored in soft reset", 2'd0, 1'b0, 1'b0, 3'b111);
        @(negedge clk); rst_n = 1'b1;
        step(1'b1, 2'd0, KA, 3'b111);
        check_all("R2 lock after soft reset", 2'd1, 1'b0, 1'b0, 3'b000);
        @(negedge clk); rst_n = 1'b0;
        step(1'b1, 2'd1, KB, 3'b111);
        check_all("R9 no key error in soft reset", 2'd1, 1'b0, 1'b0, 3'b000);
        step(1'b1, 2'd1, KA, 3'b111);
        check_all("R9 no unlock in soft reset", 2'd1, 1'b0, 1'b0, 3'b000);
        @(negedge clk); rst_n = 1'b1;

        // R6: otp set while key-locked, then R5 seal from key-locked
        step(1'b1, 2'd3, KA, 3'b111);
        check_all("R6 otp while locked", 2'd1, 1'b1, 1'b0, 3'b000);
        step(1'b1, 2'd2, KA, 3'b111);
        check_all("R5 seal from key-locked", 2'd2, 1'b1, 1'b0, 3'b000);
        step(1'b1, 2'd1, KA, 3'b111);
        check_all("R5 sealed ignores right key", 2'd2, 1'b1, 1'b0, 3'b000);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule